// File: doc/BRIEF.md
# Oscillator-Count Temperature Sampler

This block measures the frequency of an on-die, temperature-dependent ring oscillator by counting its rising edges against the reference clock. A single configuration word sets two durations in reference-clock cycles: how often a measurement starts, and how long the edge counter stays open within each measurement. At the end of every counting window, the block publishes the result as a count word. A status word carries a small state code and a valid flag.

The oscillator arrives as an asynchronous pulse input. It is resynchronised and edge-detected before it reaches the counter. The count stops at all-ones instead of wrapping, and that value is reported as an overflow. Turning counts into degrees, comparing them with thresholds and raising interrupts are left to a neighbouring block that decodes the two status words.

Top module: `osc_temp_sampler`

## Requirements
- R1: After reset the configuration word is zero, the status word reads state 0 (idle) with valid clear, and the count word is zero. While the period field or the window field is zero, no measurement runs and valid stays clear, even with pulses on the oscillator input.
- R2: With both fields non-zero and the stop bit clear, a counting window opens every period-field cycles. The result is the number of oscillator rising edges seen during the window, within one edge. The state reads 3 while the window is open and 2 between windows.
- R3: The configuration word holds the stop control at bit 0, the 16-bit period at bits 23:8 and the 8-bit window length at bits 31:24. A write takes effect at the clock edge that samples the write strobe.
- R4: The status word carries the state code in bits 2:0 and valid in bit 9, and every other bit is zero. The count word carries the count in bits 31:16 (zero-extended) and zero in bits 15:0. State codes are: 0 idle, 1 stopped, 2 waiting, 3 counting, 5 overflow.
- R5: Valid rises only when a complete window has ended since the last configuration write. A window of W cycles makes valid visible W cycles after the write edge and not before. The count and valid change at the same clock edge.
- R6: The count saturates at all ones of its width. While the latest valid result is saturated, the overflow output is high and the state reads 5. A later unsaturated result clears both.
- R7: With the stop bit set the state reads 1, valid is clear, no window opens and the previous count is held. Clearing the stop bit resumes measuring.
- R8: Any configuration write restarts the period timer, abandons an open window without publishing it, and clears valid.
- R9: When the window field is at least the period field, the window is cut to the period, so a result is still published once per period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration word: stop, period, window |
| osc_in | input | 1 | Asynchronous oscillator pulse input |
| status_word | output | 32 | State code (2:0) and valid flag (9) |
| count_word | output | 32 | Latest count in bits 31:16 |
| overflow_o | output | 1 | Latest valid count is saturated |

## Verification
The hardest case to reach is saturation. With the default 16-bit count, the counter would need tens of thousands of synchronised edges in one window. The bench therefore builds the block with a narrow count and drives the oscillator at the fastest rate the synchronizer can resolve, one edge every two cycles, over a long window, so the count passes all-ones. It then slows the oscillator and waits for a full later period, to show that the overflow state clears. The abandoned-window case is reached by rewriting the configuration halfway through a long window. The bench then checks that valid stays low past the time the old window would have closed.

// File: rtl/osc_sampler_pkg.sv
`timescale 1ns/1ps
package osc_sampler_pkg;

    localparam int CFG_W     = 32;
    localparam int PER_W     = 16;
    localparam int WIN_W     = 8;
    localparam int VALID_BIT = 9;

    // bit 31:24 window, 23:8 period, 7:1 reserved, 0 stop
    typedef struct packed {
        logic [WIN_W-1:0] win;
        logic [PER_W-1:0] per;
        logic [6:0]       rsvd;
        logic             halt;
    } chan_cfg_t;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_HALT  = 3'd1,
        ST_GAP   = 3'd2,
        ST_COUNT = 3'd3,
        ST_SAT   = 3'd5
    } chan_state_e;

    function automatic logic [PER_W-1:0] eff_window(logic [WIN_W-1:0] win,
                                                    logic [PER_W-1:0] per);
        logic [PER_W-1:0] w;
        w = PER_W'(win);
        return (w < per) ? w : per;
    endfunction

endpackage

// File: rtl/osc_edge_sync.sv
`timescale 1ns/1ps
module osc_edge_sync (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic rise_o
);
    logic meta_q, sync_q, prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            meta_q <= async_in;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign rise_o = sync_q & ~prev_q;
endmodule

// File: rtl/osc_period_timer.sv
`timescale 1ns/1ps
module osc_period_timer
    import osc_sampler_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             run,
    input  logic [PER_W-1:0] per_len,
    input  logic [WIN_W-1:0] win_len,
    output logic             win_open,
    output logic             win_first,
    output logic             win_last
);
    logic [PER_W-1:0] tick_q;
    logic [PER_W-1:0] eff_len;

    assign eff_len = eff_window(win_len, per_len);

    always_ff @(posedge clk) begin
        if (rst || restart || !run)
            tick_q <= '0;
        else if (tick_q == per_len - PER_W'(1))
            tick_q <= '0;
        else
            tick_q <= tick_q + PER_W'(1);
    end

    assign win_open  = run && (tick_q < eff_len);
    assign win_first = win_open && (tick_q == '0);
    assign win_last  = win_open && (tick_q == eff_len - PER_W'(1));
endmodule

// File: rtl/osc_pulse_counter.sv
`timescale 1ns/1ps
module osc_pulse_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             abort,
    input  logic             pulse,
    input  logic             win_open,
    input  logic             win_first,
    input  logic             win_last,
    output logic [CNT_W-1:0] result,
    output logic             valid
);
    localparam logic [CNT_W-1:0] ALL_ONES = '1;

    logic [CNT_W-1:0] acc_q, base, sum;

    always_comb begin
        base = win_first ? '0 : acc_q;
        sum  = (base == ALL_ONES) ? ALL_ONES : base + CNT_W'(pulse);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q  <= '0;
            result <= '0;
            valid  <= 1'b0;
        end else begin
            if (win_open)
                acc_q <= sum;
            if (abort)
                valid <= 1'b0;
            else if (win_last) begin
                result <= sum;
                valid  <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/osc_temp_sampler.sv
`timescale 1ns/1ps
module osc_temp_sampler
    import osc_sampler_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_we,
    input  logic [31:0] cfg_wdata,
    input  logic        osc_in,
    output logic [31:0] status_word,
    output logic [31:0] count_word,
    output logic        overflow_o
);
    chan_cfg_t        cfg_q;
    chan_state_e      state;
    logic             run, rise, win_open, win_first, win_last, valid;
    logic [CNT_W-1:0] result;

    always_ff @(posedge clk) begin
        if (rst)
            cfg_q <= '0;
        else if (cfg_we)
            cfg_q <= chan_cfg_t'(cfg_wdata);
    end

    assign run = !cfg_q.halt && (cfg_q.per != '0) && (cfg_q.win != '0);

    osc_edge_sync u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (osc_in),
        .rise_o   (rise)
    );

    osc_period_timer u_timer (
        .clk       (clk),
        .rst       (rst),
        .restart   (cfg_we),
        .run       (run),
        .per_len   (cfg_q.per),
        .win_len   (cfg_q.win),
        .win_open  (win_open),
        .win_first (win_first),
        .win_last  (win_last)
    );

    osc_pulse_counter #(.CNT_W(CNT_W)) u_count (
        .clk       (clk),
        .rst       (rst),
        .abort     (cfg_we),
        .pulse     (rise),
        .win_open  (win_open),
        .win_first (win_first),
        .win_last  (win_last),
        .result    (result),
        .valid     (valid)
    );

    assign overflow_o = valid && (result == '1);

    always_comb begin
        if (cfg_q.halt)                              state = ST_HALT;
        else if (cfg_q.per == '0 || cfg_q.win == '0) state = ST_IDLE;
        else if (overflow_o)                         state = ST_SAT;
        else if (win_open)                           state = ST_COUNT;
        else                                         state = ST_GAP;
    end

    always_comb begin
        status_word            = '0;
        status_word[2:0]       = state;
        status_word[VALID_BIT] = valid;
        count_word             = {16'(result), 16'h0000};
    end
endmodule

// File: rtl/osc_temp_sampler_chk.sv
`timescale 1ns/1ps
module osc_temp_sampler_chk #(
    parameter int CNT_W = 16
) (
    input logic        clk,
    input logic        rst,
    input logic        cfg_we,
    input logic [31:0] status_word,
    input logic [31:0] count_word,
    input logic        overflow_o
);
    localparam logic [CNT_W-1:0] SAT_VAL = '1;

    // R8: a configuration write clears valid at the next edge
    a_r8_write_clears_valid: assert property (@(posedge clk) disable iff (rst)
        cfg_we |=> !status_word[9]);

    // R1: idle never shows a valid result
    a_r1_idle_not_valid: assert property (@(posedge clk) disable iff (rst)
        (status_word[2:0] == 3'd0) |-> !status_word[9]);

    // R7: stopped channel never shows a valid result
    a_r7_halt_not_valid: assert property (@(posedge clk) disable iff (rst)
        (status_word[2:0] == 3'd1) |-> !status_word[9]);

    // R5: the count only moves together with a valid result
    a_r5_count_with_valid: assert property (@(posedge clk) disable iff (rst)
        !$stable(count_word) |-> status_word[9]);

    // R5: valid rises only after a counting cycle
    a_r5_valid_after_count: assert property (@(posedge clk) disable iff (rst)
        $rose(status_word[9]) |-> ($past(status_word[2:0]) == 3'd3));

    // R6: overflow means state 5 and a saturated count field
    a_r6_sat_state: assert property (@(posedge clk) disable iff (rst)
        overflow_o |-> (status_word[2:0] == 3'd5 && count_word[31:16] == 16'(SAT_VAL)));
endmodule

bind osc_temp_sampler osc_temp_sampler_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .cfg_we      (cfg_we),
    .status_word (status_word),
    .count_word  (count_word),
    .overflow_o  (overflow_o)
);

// File: tb/sim_osc_temp_sampler.sv
`timescale 1ns/1ps
module sim_osc_temp_sampler;
    localparam int CW = 6;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic        osc = 1'b0;
    logic [31:0] status_word, count_word;
    logic        overflow_o;
    int          osc_half = 0;
    int          n_checks = 0;
    int          n_errors = 0;
    bit          done = 1'b0;

    osc_temp_sampler #(.CNT_W(CW)) u0 (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .osc_in(osc), .status_word(status_word), .count_word(count_word),
        .overflow_o(overflow_o)
    );

    always #5 clk = ~clk;

    // oscillator: toggles 2 ns before a rising clock edge, never on it
    initial begin
        #3;
        forever begin
            if (osc_half == 0) begin
                osc = 1'b0;
                #10;
            end else begin
                #(osc_half) osc = ~osc;
            end
        end
    end

    task automatic chk_eq(string req, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_near(string req, int act, int exp);
        n_checks++;
        if (act < exp - 1 || act > exp + 1) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d (+/-1)", req, act, exp);
        end
    endtask

    task automatic wait_cyc(int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic cfg_write(bit halt, int per, int win);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_wdata = {8'(win), 16'(per), 7'b0, halt};
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    function automatic int st();  return int'(status_word[2:0]); endfunction
    function automatic int vld(); return int'(status_word[9]);   endfunction
    function automatic int cnt(); return int'(count_word[31:16]); endfunction

    task automatic t_reset();
        chk_eq("R1 reset status", int'(status_word), 0);
        chk_eq("R1 reset count", int'(count_word), 0);
        chk_eq("R1 reset overflow", int'(overflow_o), 0);
        osc_half = 20;
        wait_cyc(200);
        chk_eq("R1 idle with pulses valid", vld(), 0);
        chk_eq("R1 idle state", st(), 0);
        cfg_write(0, 100, 0);
        wait_cyc(250);
        chk_eq("R1 zero window valid", vld(), 0);
        chk_eq("R1 zero window state", st(), 0);
    endtask

    task automatic t_basic();
        osc_half = 20;
        cfg_write(0, 100, 40);
        wait_cyc(20);
        chk_eq("R2 counting state", st(), 3);
        wait_cyc(19);
        chk_eq("R5 valid not before window end", vld(), 0);
        wait_cyc(1);
        chk_eq("R5 valid at window end", vld(), 1);
        chk_near("R2 count 4-cycle osc", cnt(), 10);
        chk_eq("R4 status spare bits", int'(status_word & ~32'h0000_0207), 0);
        chk_eq("R4 count low half", int'(count_word[15:0]), 0);
        wait_cyc(30);
        chk_eq("R2 waiting state", st(), 2);
        chk_eq("R3 field decode state", st(), 2);
    endtask

    task automatic t_freq();
        osc_half = 40;
        wait_cyc(200);
        chk_near("R2 count 8-cycle osc", cnt(), 5);
        osc_half = 0;
        wait_cyc(200);
        chk_eq("R2 silent osc count", cnt(), 0);
        chk_eq("R2 silent osc valid", vld(), 1);
        chk_eq("R6 silent no overflow", int'(overflow_o), 0);
    endtask

    task automatic t_clip();
        osc_half = 20;
        cfg_write(0, 50, 200);
        wait_cyc(49);
        chk_eq("R9 clipped valid early", vld(), 0);
        wait_cyc(1);
        chk_eq("R9 clipped valid at period", vld(), 1);
        chk_near("R9 clipped count", cnt(), 12);
    endtask

    task automatic t_restart();
        cfg_write(0, 1000, 200);
        chk_eq("R8 write clears valid", vld(), 0);
        wait_cyc(100);
        cfg_write(0, 1000, 200);
        chk_eq("R8 rewrite valid clear", vld(), 0);
        wait_cyc(150);
        chk_eq("R8 old window abandoned", vld(), 0);
        wait_cyc(50);
        chk_eq("R8 restarted window ends", vld(), 1);
    endtask

    task automatic t_halt();
        int held;
        osc_half = 20;
        cfg_write(0, 100, 40);
        wait_cyc(100);
        chk_eq("R7 running valid", vld(), 1);
        held = cnt();
        cfg_write(1, 100, 40);
        chk_eq("R7 stop state", st(), 1);
        chk_eq("R7 stop clears valid", vld(), 0);
        chk_eq("R7 stop holds count", cnt(), held);
        wait_cyc(300);
        chk_eq("R7 no windows while stopped", vld(), 0);
        chk_eq("R7 count still held", cnt(), held);
        cfg_write(0, 100, 40);
        wait_cyc(40);
        chk_eq("R7 resume valid", vld(), 1);
        chk_near("R7 resume count", cnt(), 10);
    endtask

    task automatic t_sat();
        osc_half = 10;
        cfg_write(0, 300, 200);
        wait_cyc(200);
        chk_eq("R6 saturated valid", vld(), 1);
        chk_eq("R6 saturated count", cnt(), (1 << CW) - 1);
        chk_eq("R6 overflow high", int'(overflow_o), 1);
        chk_eq("R6 overflow state", st(), 5);
        osc_half = 40;
        wait_cyc(600);
        chk_near("R6 recovered count", cnt(), 25);
        chk_eq("R6 overflow cleared", int'(overflow_o), 0);
        n_checks++;
        if (st() == 5) begin
            n_errors++;
            $display("FAIL R6 state after recovery: actual=%0d expected=2 or 3", st());
        end
    endtask

    initial begin
        wait_cyc(4);
        rst = 1'b0;
        wait_cyc(1);
        t_reset();
        t_basic();
        t_freq();
        t_clip();
        t_restart();
        t_halt();
        t_sat();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        #500000;
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule